// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches a group of general-purpose input lines and turns activity on them into interrupt requests. Each line passes through a two-stage synchroniser. A per-line configuration then decides how the line is sensed: by level (high or low), by a single edge (rising or falling), or by any edge. Detected events are kept in a raw status vector. That vector is gated by a per-line enable to form the masked status, and the OR of the masked status drives one interrupt output.

Software reaches the block through a narrow register port that is one byte wide. Writes take effect on the clock edge where the port is selected with the write strobe high. Reads return data combinationally in the same cycle. The port is a plain control interface, so it has no valid/ready handshake and never stalls: every selected access completes in its own cycle. Edge events stay latched until software clears them by writing ones to the clear register. Level events follow the line itself.

Top module: `gid_top`

## Requirements
- R1: After reset the enable, sense, any-edge, polarity and raw status registers all read 0, and `irq_o` is low.
- R2: With sense=0, any-edge=0 and polarity=1 on a line, a rising edge of that line sets its raw status bit and a falling edge does not.
- R3: With sense=0, any-edge=0 and polarity=0 on a line, a falling edge sets its raw status bit and a rising edge does not.
- R4: With sense=0 and any-edge=1, both rising and falling edges set the raw status bit, whatever the polarity bit holds.
- R5: With sense=1, the raw status bit is 1 exactly while the synchronised line equals the polarity bit (1 = high, 0 = low). It drops without any clear write.
- R6: An edge-sensitive raw bit stays set until a 1 is written to the same bit of the clear register. Writing 0 bits to the clear register changes nothing, and clear writes have no effect on level-sensitive lines.
- R7: When a new edge and a clear of the same bit fall on the same cycle, the bit ends up set.
- R8: The masked status reads as raw status AND enable. `irq_o` is high exactly when some masked bit is 1.
- R9: The enable, sense, any-edge and polarity registers read back what was written, and the clear register always reads 0. Register offsets: 0 enable, 1 sense, 2 any-edge, 3 polarity, 4 raw status (read-only), 5 masked status (read-only), 6 clear (write-only).
- R10: A change on an input line reaches the raw status on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | 8 | Asynchronous input lines |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a selected read, 0 otherwise |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the register port carries only offsets 0 to 6 while selected, and that the write strobe is meaningful only together with the select. They also assume the input lines may change at any time, since the synchroniser absorbs that. The stimulus drives every input half a period away from the sampling edge and uses only the listed offsets. It times clear writes to the exact cycle where an edge is detected, so that the collision rule is exercised. A behavioural model in the bench predicts the interrupt output on every cycle and the register contents at every read.

// File: rtl/gid_pkg.sv
package gid_pkg;
  localparam int unsigned OFF_ENABLE = 0;
  localparam int unsigned OFF_SENSE  = 1;
  localparam int unsigned OFF_ANY    = 2;
  localparam int unsigned OFF_POL    = 3;
  localparam int unsigned OFF_RAW    = 4;
  localparam int unsigned OFF_MASKED = 5;
  localparam int unsigned OFF_CLEAR  = 6;
endpackage

// File: rtl/gid_sync.sv
module gid_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= async_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gid_detect.sv
module gid_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] any_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] edge_o,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= cur_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    logic rise, fall, lvl_hit, nxt;
    assign rise    = cur_i[i] & ~prev_q[i];
    assign fall    = ~cur_i[i] & prev_q[i];
    assign edge_o[i] = any_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign lvl_hit = (cur_i[i] == pol_i[i]);

    always_comb begin
      if (sense_i[i]) nxt = lvl_hit;
      else nxt = edge_o[i] | (raw_o[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_o[i] <= 1'b0;
      else raw_o[i] <= nxt;
    end
  end
endmodule

// File: rtl/gid_regs.sv
module gid_regs
  import gid_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  input  logic [N-1:0]  raw_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  sense_o,
  output logic [N-1:0]  any_o,
  output logic [N-1:0]  pol_o,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  rdata_o
);
  logic wr_hit, rd_hit;
  assign wr_hit = bus_sel & bus_wr;
  assign rd_hit = bus_sel & ~bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= '0;
      sense_o <= '0;
      any_o   <= '0;
      pol_o   <= '0;
    end else if (wr_hit) begin
      if (bus_addr == AW'(OFF_ENABLE)) en_o    <= bus_wdata;
      if (bus_addr == AW'(OFF_SENSE))  sense_o <= bus_wdata;
      if (bus_addr == AW'(OFF_ANY))    any_o   <= bus_wdata;
      if (bus_addr == AW'(OFF_POL))    pol_o   <= bus_wdata;
    end
  end

  assign clr_o = (wr_hit && bus_addr == AW'(OFF_CLEAR)) ? bus_wdata : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      if (bus_addr == AW'(OFF_ENABLE)) rdata_o = en_o;
      if (bus_addr == AW'(OFF_SENSE))  rdata_o = sense_o;
      if (bus_addr == AW'(OFF_ANY))    rdata_o = any_o;
      if (bus_addr == AW'(OFF_POL))    rdata_o = pol_o;
      if (bus_addr == AW'(OFF_RAW))    rdata_o = raw_i;
      if (bus_addr == AW'(OFF_MASKED)) rdata_o = raw_i & en_o;
    end
  end
endmodule

// File: rtl/gid_top.sv
module gid_top #(
  parameter int unsigned N      = 8,
  parameter int unsigned AW     = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  lines_i,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic          irq_o
);
  logic [N-1:0] cur_w, en_w, sense_w, any_w, pol_w, clr_w, edge_w, raw_w;

  gid_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lines_i), .sync_o(cur_w)
  );

  gid_regs #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .raw_i(raw_w),
    .en_o(en_w), .sense_o(sense_w), .any_o(any_w), .pol_o(pol_w),
    .clr_o(clr_w), .rdata_o(bus_rdata)
  );

  gid_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_n), .cur_i(cur_w), .sense_i(sense_w),
    .any_i(any_w), .pol_i(pol_w), .clr_i(clr_w),
    .edge_o(edge_w), .raw_o(raw_w)
  );

  assign irq_o = |(raw_w & en_w);
endmodule

// File: rtl/gid_chk.sv
module gid_chk
  import gid_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_rdata,
  input logic          irq_o,
  input logic [N-1:0]  cur,
  input logic [N-1:0]  sense,
  input logic [N-1:0]  pol,
  input logic [N-1:0]  en,
  input logic [N-1:0]  clr,
  input logic [N-1:0]  edge_hit,
  input logic [N-1:0]  raw
);
  logic [N-1:0] keep, cleared, fresh, lvl_match;
  assign keep      = raw & ~sense & ~clr;
  assign cleared   = clr & ~sense & ~edge_hit;
  assign fresh     = edge_hit & ~sense;
  assign lvl_match = ~(cur ^ pol);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (raw == '0 && en == '0 && irq_o == 1'b0);
    end
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(keep)) == $past(keep)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(cleared)) == '0));

  p_setwins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(fresh)) == $past(fresh)));

  p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((raw ^ $past(lvl_match)) & $past(sense)) == '0));

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(OFF_MASKED)) |-> (bus_rdata == (raw & en)));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & en) != '0) |-> irq_o);

  p_clrread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(OFF_CLEAR)) |-> (bus_rdata == '0));
endmodule

bind gid_top gid_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o),
  .cur(cur_w), .sense(sense_w), .pol(pol_w), .en(en_w), .clr(clr_w),
  .edge_hit(edge_w), .raw(raw_w)
);

// File: tb/gid_top_tb.sv
`timescale 1ns/1ps
module gid_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] lines = '0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  gid_top dut_i (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [7:0] m_cur, m_prev, m_raw, m_en, m_sense, m_any, m_pol;
  logic [7:0] m_pipe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_prev = 0; m_raw = 0; m_en = 0; m_sense = 0; m_any = 0; m_pol = 0;
      m_pipe = {8'h00};
    end else begin
      logic [7:0] nraw;
      logic [7:0] clrm;
      clrm = (bus_sel && bus_wr && bus_addr == 3'd6) ? bus_wdata : 8'h00;
      for (int i = 0; i < 8; i++) begin
        bit rise, fall, hit;
        rise = m_cur[i] && !m_prev[i];
        fall = !m_cur[i] && m_prev[i];
        hit  = m_any[i] ? (rise || fall) : (m_pol[i] ? rise : fall);
        if (m_sense[i]) nraw[i] = (m_cur[i] == m_pol[i]);
        else nraw[i] = hit || (m_raw[i] && !clrm[i]);
      end
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          3'd0: m_en = bus_wdata;
          3'd1: m_sense = bus_wdata;
          3'd2: m_any = bus_wdata;
          3'd3: m_pol = bus_wdata;
          default: ;
        endcase
      end
      m_prev = m_cur;
      m_cur  = m_pipe.pop_front();
      m_pipe.push_back(lines);
      m_raw  = nraw;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_en;
      3'd1: return m_sense;
      3'd2: return m_any;
      3'd3: return m_pol;
      3'd4: return m_raw;
      3'd5: return m_raw & m_en;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R8: interrupt output compared with the model every cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) check("R8 irq", {7'd0, irq_o}, {7'd0, |(m_raw & m_en)});
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  // read and compare against the model and a literal
  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] lit);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp_rd(a));
    check(req, bus_rdata, lit);
    bus_sel = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 7; a++) rd("R1 reset", 3'(a), 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // R9 readback
    wr(3'd0, 8'hFF);
    rd("R9 enable", 3'd0, 8'hFF);
    wr(3'd3, 8'h09);  // line0 rising, line3 high
    rd("R9 polarity", 3'd3, 8'h09);

    // R10 latency + R2 rising
    @(negedge clk); lines[0] = 1;
    @(negedge clk); @(negedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = 3'd4; #1;
    check("R10 not yet", bus_rdata, 8'h00);
    @(negedge clk); #1;
    check("R10 third edge", bus_rdata, 8'h01);
    check("R2 rising", bus_rdata, exp_rd(3'd4));
    bus_sel = 0;
    // R6 sticky after fall, R2 no set on fall
    lines[0] = 0; wait_cyc(4);
    rd("R6 sticky", 3'd4, 8'h01);
    wr(3'd6, 8'h00);
    rd("R6 zero write", 3'd4, 8'h01);
    wr(3'd6, 8'h01);
    rd("R6 cleared", 3'd4, 8'h00);
    rd("R2 fall ignored", 3'd4, 8'h00);

    // R3 falling on line1 (polarity 0)
    @(negedge clk); lines[1] = 1; wait_cyc(4);
    rd("R3 rise ignored", 3'd4, 8'h00);
    lines[1] = 0; wait_cyc(4);
    rd("R3 falling", 3'd4, 8'h02);
    wr(3'd6, 8'h02);

    // R4 any edge on line2, polarity bit 0 ignored
    wr(3'd2, 8'h04);
    @(negedge clk); lines[2] = 1; wait_cyc(4);
    rd("R4 rise", 3'd4, 8'h04);
    wr(3'd6, 8'h04);
    rd("R4 cleared", 3'd4, 8'h00);
    lines[2] = 0; wait_cyc(4);
    rd("R4 fall", 3'd4, 8'h04);
    wr(3'd6, 8'h04);

    // R5 level high on line3, level low on line4
    wr(3'd1, 8'h18);
    wait_cyc(2);
    rd("R5 low level active", 3'd4, 8'h10);
    @(negedge clk); lines[3] = 1; lines[4] = 1; wait_cyc(4);
    rd("R5 high level", 3'd4, 8'h08);
    wr(3'd6, 8'h08);
    rd("R6 level not cleared", 3'd4, 8'h08);
    lines[3] = 0; wait_cyc(4);
    rd("R5 drops", 3'd4, 8'h00);

    // R7 set wins over clear in the same cycle (line5 rising)
    wr(3'd3, 8'h29);
    @(negedge clk); lines[5] = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd6; bus_wdata = 8'h20;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rd("R7 set wins", 3'd4, 8'h20);

    // R8 masking
    wr(3'd0, 8'h0F);
    rd("R8 masked off", 3'd5, 8'h00);
    check("R8 irq low", {7'd0, irq_o}, 8'h00);
    wr(3'd0, 8'h20);
    rd("R8 masked on", 3'd5, 8'h20);
    check("R8 irq high", {7'd0, irq_o}, 8'h01);
    rd("R9 clear reads 0", 3'd6, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule